// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command side of a parallel NOR flash device on a synchronous system clock. The pins follow the usual flash bus: active-low chip enable, output enable and write enable, an active-low hardware reset, an address bus, and a data bus. The data bus is split into an input half, an output half and a drive-enable flag, so that an enclosing pad ring can build the bidirectional pin.

A write is taken as one command cycle on the first clock where the write condition holds. Multi-cycle sequences move the block between array reads, word programming, an identification mode, and a shortened programming mode that skips the two unlock cycles. A small register array stands in for the flash cells, and a down-counter stands in for the embedded programming algorithm.

The bus is a strobe interface with no valid/ready pair. The only back-pressure is the busy interval. During that interval, reads return a status word and command writes are dropped, so a host must poll until a read returns array data before it issues further commands.

Top module: `pflash_cmd_ctrl`

## Requirements
- R1: After power-up and after every hardware reset, the block is in array-read mode. Reads need no command first, and every word of a fresh array reads as all ones.
- R2: A read cycle is chip enable low, output enable low and write enable high. Only then is `dq_oe` high, and `dq_o` carries the word at address bits [5:0]. While output enable is high, `dq_oe` is low.
- R3: A write cycle is chip enable low, write enable low and output enable high. A cycle with output enable low is not a write. A write condition held over many clocks counts as one command cycle.
- R4: A normal program takes four write cycles: 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the target address and data. The stored word becomes old AND data, so programming only clears bits. The new value reads back once BUSY_CYC clocks have passed after the data cycle.
- R5: The sequence 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enters bypass mode. In bypass mode, a program is 0xA0 at any address followed by address and data, and the block stays in bypass afterwards. Array reads still work in bypass mode. Writing 0x90 and then 0x00 leaves bypass mode.
- R6: The sequence 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 enters identification mode. Reads then return MFR_ID when address bit 0 is 0 and DEV_ID when it is 1, on bits [7:0], with bits [15:8] zero. The mode lasts until the next write.
- R7: A wrong address or wrong data value at any command step returns the block to array-read mode, including inside bypass mode. A later step of the broken sequence therefore programs nothing.
- R8: A write whose low byte is 0xF0, in any command step other than a program data cycle, forces array-read mode. This leaves both bypass mode and identification mode.
- R9: For BUSY_CYC clocks after a program data cycle, reads return the status word: bit 7 is the inverse of bit 7 of the programmed data, and every other bit is 0. Every write in that interval is ignored, 0xF0 included.
- R10: While `rst_n` is low, `dq_oe` stays low and writes are ignored. A program in progress is abandoned without changing the array, and the block returns to array-read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assertion |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address; bits [10:0] decode commands, bits [5:0] index the array |
| dq_i | input | DATA_W | Data bus, value driven in by the host |
| dq_o | output | DATA_W | Data bus, value the block drives out |
| dq_oe | output | 1 | High when the block drives the data bus; low means high impedance |

## Verification
The main function is driven through the full four-cycle program, the two-cycle bypass program, the identification sequence, and deliberately broken sequences. The broken sequences use a wrong unlock address, a wrong unlock byte, a stray byte inside bypass mode, and a command step given with output enable low. Comparing programs that land against broken sequences that must leave a word at all ones separates correct step tracking from a decoder that only checks the final cycle.

Writes issued during the busy interval and during a reset pulse show whether commands are really locked out. Re-programming an already written word with a second value shows that the array keeps the AND of the two values rather than the latest write.

A behavioural model in the bench predicts the drive flag and the read word on every clock, alongside the directed checks.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  // Command-step tracker states
  typedef enum logic [2:0] {
    ST_ARRAY,    // array reads
    ST_UNL1,     // first unlock cycle seen
    ST_UNL2,     // second unlock cycle seen
    ST_PGM_ARM,  // next write is program address/data
    ST_IDENT,    // identification reads
    ST_BYP,      // bypass idle
    ST_BYP_ARM,  // bypass: next write is program address/data
    ST_BYP_EXIT  // bypass: waiting for exit confirm
  } cmd_st_e;

  localparam int unsigned CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] BYTE_KEY_A  = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B  = 8'h55;
  localparam logic [7:0] BYTE_PGM    = 8'hA0;
  localparam logic [7:0] BYTE_IDENT  = 8'h90;
  localparam logic [7:0] BYTE_BYPASS = 8'h20;
  localparam logic [7:0] BYTE_ABORT  = 8'hF0;
  localparam logic [7:0] BYTE_EXIT   = 8'h00;

endpackage

// File: rtl/pflash_busy_timer.sv
module pflash_busy_timer #(
  parameter int unsigned BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(BUSY_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9

endmodule

// File: rtl/pflash_seq_fsm.sv
module pflash_seq_fsm
  import pflash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic              busy,
  output logic              pgm_go,
  output logic              ident_mode
);
  cmd_st_e state, nxt;
  logic    take;
  logic    data_step;

  assign take      = wr_stb && !busy;
  assign data_step = (state == ST_PGM_ARM) || (state == ST_BYP_ARM);

  always_comb begin
    nxt    = state;
    pgm_go = 1'b0;
    if (take) begin
      unique case (state)
        ST_ARRAY, ST_IDENT:
          nxt = (wr_byte == BYTE_KEY_A && wr_addr == ADR_KEY_A) ? ST_UNL1 : ST_ARRAY;
        ST_UNL1:
          nxt = (wr_byte == BYTE_KEY_B && wr_addr == ADR_KEY_B) ? ST_UNL2 : ST_ARRAY;
        ST_UNL2: begin
          nxt = ST_ARRAY;
          if (wr_addr == ADR_KEY_A) begin
            if (wr_byte == BYTE_PGM)         nxt = ST_PGM_ARM;
            else if (wr_byte == BYTE_IDENT)  nxt = ST_IDENT;
            else if (wr_byte == BYTE_BYPASS) nxt = ST_BYP;
          end
        end
        ST_PGM_ARM: begin
          pgm_go = 1'b1;
          nxt    = ST_ARRAY;
        end
        ST_BYP: begin
          if (wr_byte == BYTE_PGM)        nxt = ST_BYP_ARM;
          else if (wr_byte == BYTE_IDENT) nxt = ST_BYP_EXIT;
          else                            nxt = ST_ARRAY;
        end
        ST_BYP_ARM: begin
          pgm_go = 1'b1;
          nxt    = ST_BYP;
        end
        ST_BYP_EXIT:
          nxt = ST_ARRAY; // 0x00 confirms; any other byte is malformed
        default: nxt = ST_ARRAY;
      endcase
      if (!data_step && wr_byte == BYTE_ABORT) nxt = ST_ARRAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ARRAY;
    else        state <= nxt;
  end

  assign ident_mode = (state == ST_IDENT);

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(state)); // R9
  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BYP && $past(state) != ST_BYP) |->
      ($past(state) == ST_UNL2 || $past(state) == ST_BYP_ARM)); // R5
  AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDENT && $past(state) != ST_IDENT) |-> $past(state) == ST_UNL2); // R6

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_mask,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  // Power-up contents: erased cells read as all ones
  initial begin
    for (int i = 0; i < int'(WORDS); i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= mem[wr_idx] & wr_mask;
  end

  assign rd_data = mem[rd_idx];

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(wr_idx)] & ~$past(mem[wr_idx])) == '0)); // R4

endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WORDS    = 64,
  parameter int unsigned BUSY_CYC = 8,
  parameter logic [7:0]  MFR_ID   = 8'h5A,
  parameter logic [7:0]  DEV_ID   = 8'hB3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic              wr_cond, wr_q, wr_stb, rd_cond;
  logic              busy, done, pgm_go, ident_mode;
  logic [IDX_W-1:0]  pend_idx;
  logic [DATA_W-1:0] pend_data, arr_word, status_word, ident_word;

  assign wr_cond = !ce_n && !we_n && oe_n;
  assign rd_cond = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_cond;
  end

  assign wr_stb = wr_cond && !wr_q;

  pflash_seq_fsm u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (addr[CMD_AW-1:0]),
    .wr_byte    (dq_i[7:0]),
    .busy       (busy),
    .pgm_go     (pgm_go),
    .ident_mode (ident_mode)
  );

  pflash_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pgm_go),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx  <= '0;
      pend_data <= '1;
    end else if (pgm_go) begin
      pend_idx  <= addr[IDX_W-1:0];
      pend_data <= dq_i;
    end
  end

  pflash_array #(.DATA_W(DATA_W), .WORDS(WORDS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (done),
    .wr_idx  (pend_idx),
    .wr_mask (pend_data),
    .rd_idx  (addr[IDX_W-1:0]),
    .rd_data (arr_word)
  );

  always_comb begin
    status_word    = '0;
    status_word[7] = ~pend_data[7];
    ident_word     = '0;
    ident_word[7:0] = addr[0] ? DEV_ID : MFR_ID;
  end

  assign dq_oe = rst_n && rd_cond;
  assign dq_o  = busy ? status_word : (ident_mode ? ident_word : arr_word);

  AST_NO_IDENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ident_mode); // R6
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3

endmodule

// File: tb/pflash_cmd_ctrl_tb.sv
module pflash_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 8;
  localparam int WORDS      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic        dq_oe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_cmd_ctrl #(.BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // Behavioural reference model
  int mem_m [int];
  int stage = 0;          // 0 idle, 1 key A seen, 2 key B seen, 3 armed, 4 exit wait, 5 bypass armed
  bit in_byp = 0, in_id = 0, prev_wr = 0;
  int busy_left = 0, pend_a = 0, pend_d = 'hFFFF;

  function automatic int mem_get(int a);
    return mem_m.exists(a) ? mem_m[a] : 'hFFFF;
  endfunction

  task automatic model_step();
    bit wr, stb;
    int d, a;
    if (!rst_n) begin
      stage = 0; in_byp = 0; in_id = 0; prev_wr = 0; busy_left = 0; pend_d = 'hFFFF;
      return;
    end
    wr = !ce_n && !we_n && oe_n;
    stb = wr && !prev_wr;
    prev_wr = wr;
    d = int'(dq_i[7:0]);
    a = int'(addr);
    if (busy_left > 0) begin
      if (busy_left == 1) mem_m[pend_a] = mem_get(pend_a) & pend_d;
      busy_left--;
    end else if (stb) begin
      if (stage == 3 || stage == 5) begin
        pend_a = a % WORDS; pend_d = int'(dq_i); busy_left = BUSY_CYC;
        stage = 0;                 // bypass flag decides where we idle
      end else if (d == 'hF0) begin
        stage = 0; in_byp = 0; in_id = 0;
      end else if (in_byp && stage == 0) begin
        if (d == 'hA0) stage = 5;
        else if (d == 'h90) stage = 4;
        else in_byp = 0;
      end else if (stage == 4) begin
        stage = 0; in_byp = 0;
      end else if (stage == 1) begin
        stage = (d == 'h55 && a == 'h2AA) ? 2 : 0;
      end else if (stage == 2) begin
        stage = 0;
        if (a == 'h555 && d == 'hA0) stage = 3;
        else if (a == 'h555 && d == 'h90) in_id = 1;
        else if (a == 'h555 && d == 'h20) in_byp = 1;
      end else begin
        in_id = 0;
        stage = (d == 'hAA && a == 'h555) ? 1 : 0;
      end
    end
  endtask

  function automatic int model_word();
    if (busy_left > 0) return ((pend_d >> 7) & 1) ? 0 : 'h0080;
    if (in_id) return addr[0] ? 'h00B3 : 'h005A;
    return mem_get(int'(addr) % WORDS);
  endfunction

  always @(posedge clk) begin
    bit exp_oe;
    model_step();
    #1;
    exp_oe = rst_n && !ce_n && !oe_n && we_n;
    checks++;
    if (dq_oe !== exp_oe || (exp_oe && int'(dq_o) != model_word())) begin
      fails++;
      $display("FAIL R2 cycle model: oe %0b/%0b data %h expected %0b/%h",
               dq_oe, dq_o, exp_oe, exp_oe, model_word());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 11'(a); dq_i = 16'(d); ce_n = 0; oe_n = 1; we_n = 0;
    idle(2);
    we_n = 1; ce_n = 1;
  endtask

  task automatic wr_held(int a, int d, int n);
    @(negedge clk);
    addr = 11'(a); dq_i = 16'(d); ce_n = 0; oe_n = 1; we_n = 0;
    idle(n);
    we_n = 1; ce_n = 1;
  endtask

  task automatic wr_oe_low(int a, int d);
    @(negedge clk);
    addr = 11'(a); dq_i = 16'(d); ce_n = 0; oe_n = 0; we_n = 0;
    idle(2);
    we_n = 1; ce_n = 1; oe_n = 1;
  endtask

  task automatic chk_rd(int a, int exp, string tag);
    @(negedge clk);
    addr = 11'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(posedge clk); #2;
    checks++;
    if (dq_oe !== 1'b1 || int'(dq_o) != exp) begin
      fails++;
      $display("FAIL %s read @%h: oe %0b data %h, expected oe 1 data %h", tag, a, dq_oe, dq_o, exp);
    end
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic chk_quiet(string tag);
    @(posedge clk); #2;
    checks++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL %s: dq_oe %0b expected 0", tag, dq_oe);
    end
  endtask

  task automatic unlock();
    wr('h555, 'hAA);
    wr('h2AA, 'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset keeps the bus quiet even with a read condition present
    ce_n = 0; oe_n = 0; we_n = 1;
    chk_quiet("R10 quiet in reset");
    @(negedge clk); rst_n = 1; ce_n = 1; oe_n = 1;
    // R1: fresh array reads all ones without any command
    chk_rd(5, 'hFFFF, "R1");
    // R2: output enable high means no drive
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
    chk_quiet("R2 oe high");
    @(negedge clk); ce_n = 1;

    // R4 + R9: four-cycle program, status while busy
    unlock(); wr('h555, 'hA0); wr(5, 'h1234);
    chk_rd(5, 'h0080, "R9 status");
    idle(BUSY_CYC);
    chk_rd(5, 'h1234, "R4 program");
    unlock(); wr('h555, 'hA0); wr(5, 'hFF00);
    idle(BUSY_CYC + 2);
    chk_rd(5, 'h1200, "R4 and-only");

    // R9: F0 and a new sequence during busy are ignored
    unlock(); wr('h555, 'hA0); wr(6, 'h00FF);
    wr('h555, 'hF0);
    chk_rd(6, 'h0000, "R9 status bit7 set data");
    idle(BUSY_CYC);
    chk_rd(6, 'h00FF, "R9 program survives writes");

    // R6: identification mode
    unlock(); wr('h555, 'h90);
    chk_rd(0, 'h005A, "R6 mfr");
    chk_rd(1, 'h00B3, "R6 dev");
    chk_rd(0, 'h005A, "R6 persists");
    // R8: F0 leaves identification
    wr(0, 'hF0);
    chk_rd(5, 'h1200, "R8 abort ident");

    // R7: wrong unlock address, wrong unlock data
    wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr(7, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(7, 'hFFFF, "R7 wrong addr");
    wr('h555, 'hAA); wr('h2AA, 'h44); wr('h555, 'hA0); wr(7, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(7, 'hFFFF, "R7 wrong data");

    // R3: command step with oe low is not a write
    unlock(); wr_oe_low('h555, 'hA0); wr(8, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(8, 'hFFFF, "R3 oe low not write");
    // R3: long held write counts once
    wr_held('h555, 'hAA, 6); wr('h2AA, 'h55); wr_held('h555, 'hA0, 5); wr(8, 'h0F00);
    idle(BUSY_CYC + 2);
    chk_rd(8, 'h0F00, "R3 held pulse");

    // R5: bypass mode
    unlock(); wr('h555, 'h20);
    chk_rd(5, 'h1200, "R5 read in bypass");
    wr(0, 'hA0); wr(9, 'h0F0F);
    idle(BUSY_CYC + 2);
    chk_rd(9, 'h0F0F, "R5 bypass program");
    wr(0, 'hA0); wr(10, 'h3333);
    idle(BUSY_CYC + 2);
    chk_rd(10, 'h3333, "R5 second bypass program");
    wr(0, 'h90); wr(0, 'h00);
    wr(0, 'hA0); wr(11, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(11, 'hFFFF, "R5 bypass exited");
    // R7: stray byte inside bypass drops to array read
    unlock(); wr('h555, 'h20); wr(0, 'h77); wr(0, 'hA0); wr(11, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(11, 'hFFFF, "R7 malformed in bypass");
    // R8: F0 leaves bypass
    unlock(); wr('h555, 'h20); wr(0, 'hF0); wr(0, 'hA0); wr(13, 'h0000);
    idle(BUSY_CYC + 2);
    chk_rd(13, 'hFFFF, "R8 abort bypass");

    // R10: reset aborts a program and ignores writes
    unlock(); wr('h555, 'hA0); wr(12, 'h0000);
    @(negedge clk); rst_n = 0; ce_n = 0; oe_n = 0; we_n = 1;
    chk_quiet("R10 quiet mid-program");
    @(negedge clk); ce_n = 1; oe_n = 1;
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h90);
    @(negedge clk); rst_n = 1;
    idle(BUSY_CYC + 2);
    chk_rd(12, 'hFFFF, "R10 program aborted");
    chk_rd(0, 'hFFFF, "R10 array mode after reset");

    idle(3);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule